// File: doc/BRIEF.md
# Prescaled Timer with Byte Compare Channels

This block is a timer peripheral of the kind found beside a small processor core. A divide-by-1, 2, 4 or 8 prescaler turns the input clock into a one-cycle tick. A 16-bit up-counter advances on each tick while the timer is enabled. When the counter wraps, it raises an overflow flag for one tick period. Four 8-bit compare registers are each checked for equality against the low byte of the counter. Each register drives its own match output, which software-facing logic can use to time short delays.

The compare registers are loaded through a small valid/ready write port. A byte, with a 2-bit channel number beside it, is offered on `wr_valid`. The port takes it only on a prescaler tick, and `wr_ready` is that tick. Back-pressure rules: a source that raises `wr_valid` keeps `wr_data` and `wr_chan` stable until it sees `wr_ready` high at a clock edge. `wr_ready` may rise whether or not `wr_valid` is high. A transfer happens only in a cycle where both are high, and it writes at most one register. The control and status pins are plain levels. All state sits on the single clock `clk`, with a synchronous active-high reset.

Top module: `tick_compare_timer`

## Requirements
- R1: A synchronous reset clears the prescaler divider, the counter, the overflow flag and all four compare registers. After reset, `match` reads 4'b1111 and `ovf` reads 0.
- R2: `presc_sel` value k (0, 1, 2, 3) sets the tick period to 2^k enabled clocks. `wr_ready` is high in an enabled cycle exactly when the low k bits of the divider are all ones. The divider counts enabled cycles since reset, starting at 0.
- R3: While `presc_en` is 0, no tick occurs, `wr_ready` stays 0 and the divider holds its value.
- R4: The counter advances by one on each tick while `tmr_en` is 1. It holds while `tmr_en` is 0 or while there is no tick.
- R5: The tick that follows the counter value FFFFh returns the counter to 0000h and sets `ovf`. `ovf` then stays high until the next tick, so it lasts exactly one tick period.
- R6: A transfer (`wr_valid` and `wr_ready` both high) loads `wr_data` into the register numbered by `wr_chan`. Channel n drives `match[n]`, with n as the plain binary value 0 to 3. The other registers are unchanged. A write offered while `wr_ready` is 0 is ignored.
- R7: A compare register keeps its value until a transfer addressed to it.
- R8: `match[n]` is 1 when register n equals counter bits [7:0], and 0 otherwise. It is combinational from the registered values.
- R9: In the cycle of a transfer, `match` still reflects the register's old contents. The new value is visible from the following cycle.
- R10: Changing `presc_sel` does not reset the divider. The first tick after a change follows R2 applied to the current divider value, so it may come early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all state |
| rst | input | 1 | Synchronous active-high reset |
| presc_en | input | 1 | Prescaler enable; no ticks while low |
| presc_sel | input | 2 | Tick period select: 2^presc_sel clocks |
| tmr_en | input | 1 | Counter run enable |
| wr_valid | input | 1 | Compare write offered |
| wr_ready | output | 1 | Write accepted this cycle (the prescaler tick) |
| wr_chan | input | 2 | Target compare channel |
| wr_data | input | 8 | Byte to load |
| match | output | 4 | Per-channel equality with counter low byte |
| ovf | output | 1 | Counter wrapped; high for one tick period |

## Verification
`wr_ready` is combinational from the inputs and the divider, so it is due in the same cycle as the inputs that cause it. The counter, `ovf` and the compare registers change at the first rising edge at which a tick is present, and `match` shows the new values right after that edge. The bench drives inputs just after each falling edge. It compares the outputs 1 ns later against an arithmetic model in the bench, and that model advances only at rising edges. In this way every cycle checks both the same-cycle ready and the one-edge-late state, including the old-contents compare in a write cycle.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int unsigned TCT_CNT_W  = 16;
  localparam int unsigned TCT_CMP_W  = 8;
  localparam int unsigned TCT_NUM_CH = 4;
  localparam int unsigned TCT_DIV_W  = 3;
endpackage

// File: rtl/tct_prescaler.sv
module tct_prescaler #(
  parameter int unsigned DIV_W = tct_pkg::TCT_DIV_W
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             en,
  input  logic [$clog2(DIV_W+1)-1:0]       sel,
  output logic                             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] low_mask;

  always_comb begin
    low_mask = '0;
    for (int k = 0; k < DIV_W; k++) begin
      if (k < int'(sel)) low_mask[k] = 1'b1;
    end
  end

  assign tick = en && ((div_q & low_mask) == low_mask);

  always_ff @(posedge clk) begin
    if (rst)     div_q <= '0;
    else if (en) div_q <= div_q + 1'b1;
  end

  // R3: a disabled prescaler freezes its divider
  p_div_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(div_q));
  // R2: divider steps once per enabled clock, never reset by select (R10)
  p_div_step_r2: assert property (@(posedge clk) disable iff (rst)
    en |=> div_q == $past(div_q) + 1'b1);
endmodule

// File: rtl/tct_counter.sv
module tct_counter #(
  parameter int unsigned CNT_W = tct_pkg::TCT_CNT_W,
  parameter int unsigned LOW_W = tct_pkg::TCT_CMP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  output logic [LOW_W-1:0] low_byte,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             at_top;

  assign at_top   = &cnt_q;
  assign low_byte = cnt_q[LOW_W-1:0];
  assign ovf      = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (tick) begin
      ovf_q <= run && at_top;
      if (run) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: counter moves by exactly one on a running tick
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && run) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R4: counter frozen otherwise
  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(tick && run) |=> $stable(cnt_q));
  // R5: overflow only ever seen with the counter at zero
  p_ovf_zero_r5: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> cnt_q == '0);
  // R5: overflow rises only out of the top value
  p_ovf_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> $past(at_top));
endmodule

// File: rtl/tct_compare_bank.sv
module tct_compare_bank #(
  parameter int unsigned CMP_W  = tct_pkg::TCT_CMP_W,
  parameter int unsigned NUM_CH = tct_pkg::TCT_NUM_CH
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fire,
  input  logic [$clog2(NUM_CH)-1:0] chan,
  input  logic [CMP_W-1:0]          data,
  input  logic [CMP_W-1:0]          low_byte,
  output logic [NUM_CH-1:0]         match
);
  logic [NUM_CH-1:0]            strobe;
  logic [NUM_CH-1:0][CMP_W-1:0] regs_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign strobe[i] = fire && (chan == i[$clog2(NUM_CH)-1:0]);

    always_ff @(posedge clk) begin
      if (rst)            regs_q[i] <= '0;
      else if (strobe[i]) regs_q[i] <= data;
    end

    assign match[i] = (regs_q[i] == low_byte);

    // R6: addressed channel takes the offered byte
    p_load_r6: assert property (@(posedge clk) disable iff (rst)
      (fire && chan == i[$clog2(NUM_CH)-1:0]) |=> regs_q[i] == $past(data));
    // R7: unaddressed channel keeps its byte
    p_keep_r7: assert property (@(posedge clk) disable iff (rst)
      !strobe[i] |=> $stable(regs_q[i]));
  end

  // R6: the decode never selects two registers
  p_one_write_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));
endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer #(
  parameter int unsigned CNT_W  = tct_pkg::TCT_CNT_W,
  parameter int unsigned CMP_W  = tct_pkg::TCT_CMP_W,
  parameter int unsigned NUM_CH = tct_pkg::TCT_NUM_CH,
  parameter int unsigned DIV_W  = tct_pkg::TCT_DIV_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       presc_en,
  input  logic [$clog2(DIV_W+1)-1:0] presc_sel,
  input  logic                       tmr_en,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [$clog2(NUM_CH)-1:0]  wr_chan,
  input  logic [CMP_W-1:0]           wr_data,
  output logic [NUM_CH-1:0]          match,
  output logic                       ovf
);
  logic             tick;
  logic [CMP_W-1:0] low_byte;

  tct_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .en(presc_en), .sel(presc_sel), .tick(tick)
  );

  tct_counter #(.CNT_W(CNT_W), .LOW_W(CMP_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .run(tmr_en),
    .low_byte(low_byte), .ovf(ovf)
  );

  tct_compare_bank #(.CMP_W(CMP_W), .NUM_CH(NUM_CH)) u_cmp (
    .clk(clk), .rst(rst), .fire(wr_valid && tick), .chan(wr_chan),
    .data(wr_data), .low_byte(low_byte), .match(match)
  );

  assign wr_ready = tick;

  // R3: nothing accepted while the prescaler is off
  p_no_ready_r3: assert property (@(posedge clk) disable iff (rst)
    !presc_en |-> !wr_ready);
endmodule

// File: tb/tick_compare_timer_test.sv
`timescale 1ns/1ps
module tick_compare_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       presc_en = 1'b0;
  logic [1:0] presc_sel = 2'd0;
  logic       tmr_en = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [1:0] wr_chan = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [3:0] match;
  logic       ovf;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [2:0]  ref_div;
  logic [15:0] ref_cnt;
  logic        ref_ovf;
  logic [7:0]  ref_reg [4];
  logic [1:0]  prev_sel = 2'd0;

  always #2.5 clk = ~clk;

  tick_compare_timer uut (
    .clk(clk), .rst(rst), .presc_en(presc_en), .presc_sel(presc_sel),
    .tmr_en(tmr_en), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_chan(wr_chan), .wr_data(wr_data), .match(match), .ovf(ovf)
  );

  function automatic bit model_tick();
    int per;
    per = 1 << presc_sel;
    return presc_en && ((int'(ref_div) % per) == per - 1);
  endfunction

  function automatic logic [3:0] model_match();
    logic [3:0] m;
    for (int i = 0; i < 4; i++) m[i] = (ref_reg[i] == ref_cnt[7:0]);
    return m;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      ref_div <= '0; ref_cnt <= '0; ref_ovf <= 1'b0;
      for (int i = 0; i < 4; i++) ref_reg[i] <= '0;
    end else begin
      if (model_tick()) begin
        if (wr_valid) ref_reg[wr_chan] <= wr_data;
        ref_ovf <= tmr_en && (ref_cnt == 16'hFFFF);
        if (tmr_en) ref_cnt <= ref_cnt + 16'd1;
      end
      if (presc_en) ref_div <= ref_div + 3'd1;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit pe, logic [1:0] ps, bit te, bit wv,
                      logic [1:0] wc, logic [7:0] wd);
    string rtag;
    @(negedge clk);
    presc_en = pe; presc_sel = ps; tmr_en = te;
    wr_valid = wv; wr_chan = wc; wr_data = wd;
    #1;
    rtag = !pe ? "R3 ready" : (ps != prev_sel ? "R10 ready" : "R2 ready");
    check(rtag, wr_ready, model_tick());
    check((wv && model_tick()) ? "R9 match" : "R8 match", match, model_match());
    check("R5 ovf", ovf, ref_ovf);
    prev_sel = ps;
  endtask

  function automatic logic [3:0] onehot(logic [1:0] c);
    return 4'b0001 << c;
  endfunction

  initial begin
    int ovf_cycles;
    logic [7:0] keep;
    repeat (4) @(negedge clk);
    #1;
    check("R1 match after reset", match, 4'hF);
    check("R1 ovf after reset", ovf, 1'b0);
    rst = 1'b0;
    step(0, 0, 0, 0, 0, 0);
    check("R1 match after release", match, 4'hF);

    // sweep every select with writes on every channel
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 64; c++)
        step(1, s[1:0], 1, c[0], c[2:1], 8'(c * 7 + s));

    // R3: prescaler gated, with enable patterns and select changes (R10)
    for (int c = 0; c < 240; c++)
      step((c % 3) != 0, 2'((c / 5) % 4), 1, (c % 4) == 1, 2'(c % 4), 8'(c));

    // R6: write offered with prescaler off is ignored
    for (int c = 0; c < 4; c++) step(0, 0, 1, 1, 2'(c), 8'hA5);
    check("R6 ignored write keeps match", match, model_match());

    // R4: counter frozen while timer disabled; ch0 locked to low byte
    step(1, 0, 0, 0, 0, 0);
    keep = ref_cnt[7:0];
    step(1, 0, 0, 1, 2'd0, keep);
    for (int c = 0; c < 20; c++) begin
      step(1, 2'(c % 4), 0, 0, 0, 0);
      check("R4 held counter keeps match0", match[0], 1'b1);
    end

    // R6/R7: single-channel load visible next cycle, others untouched
    step(1, 0, 0, 1, 2'd2, keep);
    step(1, 0, 0, 0, 0, 0);
    check("R6 loaded channel 2 matches", match[2], 1'b1);
    check("R7 channel 0 still matches", match[0], 1'b1);

    // run toward wrap with the fastest tick
    for (int c = 0; c < 4; c++) step(1, 0, 1, 1, 2'(c), 8'hF0 + 8'(c));
    while (ref_cnt != 16'hFFF0) step(1, 0, 1, 0, 0, 0);
    ovf_cycles = 0;
    for (int c = 0; c < 200; c++) begin
      step(1, 3, 1, 0, 0, 0);
      if (ovf) ovf_cycles++;
    end
    check("R5 ovf lasts one tick period of 8 clocks", ovf_cycles, 8);
    check("R7 channel values held through wrap", match, model_match());

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule